// File: doc/BRIEF.md
# Predicated Vector Unary Operation Unit

This block executes one instruction from a family of single-source, predicated vector operations. It takes a 32-bit instruction word, a source vector, the current contents of the destination vector and a predicate mask. It decodes the element size and the operation, applies the operation to every element of the source, and writes the result into each element the predicate enables. Elements the predicate disables keep their old destination value. The vector width is a parameter with a default of 128 bits. The element size is picked at run time from 8, 16, 32 and 64 bits.

The operations fall into two groups. The bit group holds leading-sign count, leading-zero count, population count, zero test, sign-bit clear, sign-bit flip and bitwise invert. The integer group holds the sign and zero extensions from byte, halfword and word, plus absolute value and negation. An encoding that is outside both groups, or that is not allowed at the chosen size, raises the illegal flag and returns the old destination. The result is registered and is announced by a one-cycle done strobe.

Top module: `vec_unary_unit`

## Requirements
- R1: Instruction fields are major[31:24], size[23:22] (0=8, 1=16, 2=32, 3=64 bits), group[21:19] and opcode[18:16], with a fixed tag [15:13]. Bits [12:0] are ignored. A major field other than 8'h04, a tag other than 3'b101, or a group other than 3'b011 or 3'b010 is illegal.
- R2: Bit group 3'b011, opcode 3'b000 gives the count of bits below the sign bit that match the sign bit. The sign bit itself is not counted, so an all-zero or all-one element gives width-1.
- R3: In the bit group, opcode 3'b001 gives the leading-zero count (the full width for a zero element), opcode 3'b010 gives the count of one bits, and opcode 3'b011 gives 1 for a zero element and 0 otherwise.
- R4: In the bit group, opcode 3'b100 clears the element's top bit and opcode 3'b101 inverts it. All other bits pass through unchanged. Both opcodes are illegal at size 8.
- R5: In the bit group, opcode 3'b110 inverts every bit, and opcode 3'b111 is illegal.
- R6: Integer group 3'b010, opcodes 3'b000..3'b101, extend the low 8, 8, 16, 16, 32 and 32 bits: signed for even opcodes, zero-filled for odd ones. Byte extensions need a size above 8, halfword extensions need 32 or 64, and word extensions need 64. Any other size is illegal.
- R7: In the integer group, opcode 3'b110 gives the absolute value and opcode 3'b111 gives the negation, both modulo 2^width, so the most negative value maps to itself.
- R8: The predicate holds one bit per vector byte. An element is active when the predicate bit of its lowest byte is 1; the element's other predicate bits are ignored. Inactive elements keep their old destination value.
- R9: An illegal encoding sets the illegal output and returns the old destination vector unchanged. A legal encoding clears the illegal output.
- R10: The result and the illegal flag appear on the clock edge after the one that samples in_valid. done is high for exactly that one cycle. Without in_valid, the outputs hold their values.
- R11: After reset, out_vec is zero and illegal and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | VEC_W | Source vector |
| old_vec | input | VEC_W | Current destination contents |
| pred | input | VEC_W/8 | Predicate, one bit per byte |
| out_vec | output | VEC_W | New destination vector |
| illegal | output | 1 | The last instruction had an illegal encoding |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result, the illegal flag and the done strobe are due exactly one rising edge after the edge that samples in_valid. Because of that, the bench drives each operation on a falling edge, drops in_valid on the next falling edge, and samples all three outputs at that point. It then checks one falling edge later that done has fallen and that out_vec is still stable while in_valid stays low. Reset values are sampled before the first operation is issued.

// File: rtl/vu_pkg.sv
package vu_pkg;

    localparam logic [7:0] MAJOR_CODE = 8'h04;
    localparam logic [2:0] TAG_CODE   = 3'b101;
    localparam logic [2:0] GRP_BITS   = 3'b011;
    localparam logic [2:0] GRP_INTS   = 3'b010;
    localparam int         NUM_SIZES  = 4;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } elem_sz_e;

    typedef enum logic [3:0] {
        UOP_CLS,
        UOP_CLZ,
        UOP_POPC,
        UOP_ZTEST,
        UOP_SCLR,
        UOP_SFLIP,
        UOP_INV,
        UOP_SXT8,
        UOP_ZXT8,
        UOP_SXT16,
        UOP_ZXT16,
        UOP_SXT32,
        UOP_ZXT32,
        UOP_ABS,
        UOP_NEG
    } uop_e;

    typedef struct packed {
        uop_e     op;
        elem_sz_e sz;
        logic     legal;
    } dec_t;

endpackage

// File: rtl/vu_decode.sv
module vu_decode
    import vu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    logic [2:0] grp;
    logic [2:0] opc;
    logic       fixed_ok;
    logic       op_ok;
    logic       unused_fields;

    assign grp           = insn[21:19];
    assign opc           = insn[18:16];
    assign fixed_ok      = (insn[31:24] == MAJOR_CODE) && (insn[15:13] == TAG_CODE);
    assign unused_fields = ^insn[12:0];

    always_comb begin
        dec.sz = elem_sz_e'(insn[23:22]);
        dec.op = UOP_INV;
        op_ok  = 1'b0;
        case (grp)
            GRP_BITS: begin
                case (opc)
                    3'b000: begin dec.op = UOP_CLS;   op_ok = 1'b1; end
                    3'b001: begin dec.op = UOP_CLZ;   op_ok = 1'b1; end
                    3'b010: begin dec.op = UOP_POPC;  op_ok = 1'b1; end
                    3'b011: begin dec.op = UOP_ZTEST; op_ok = 1'b1; end
                    3'b100: begin dec.op = UOP_SCLR;  op_ok = (dec.sz != SZ_8); end
                    3'b101: begin dec.op = UOP_SFLIP; op_ok = (dec.sz != SZ_8); end
                    3'b110: begin dec.op = UOP_INV;   op_ok = 1'b1; end
                    default: op_ok = 1'b0;
                endcase
            end
            GRP_INTS: begin
                case (opc)
                    3'b000: begin dec.op = UOP_SXT8;  op_ok = (dec.sz != SZ_8); end
                    3'b001: begin dec.op = UOP_ZXT8;  op_ok = (dec.sz != SZ_8); end
                    3'b010: begin dec.op = UOP_SXT16; op_ok = (dec.sz == SZ_32) || (dec.sz == SZ_64); end
                    3'b011: begin dec.op = UOP_ZXT16; op_ok = (dec.sz == SZ_32) || (dec.sz == SZ_64); end
                    3'b100: begin dec.op = UOP_SXT32; op_ok = (dec.sz == SZ_64); end
                    3'b101: begin dec.op = UOP_ZXT32; op_ok = (dec.sz == SZ_64); end
                    3'b110: begin dec.op = UOP_ABS;   op_ok = 1'b1; end
                    default: begin dec.op = UOP_NEG;  op_ok = 1'b1; end
                endcase
            end
            default: op_ok = 1'b0;
        endcase
        dec.legal = fixed_ok && op_ok;
    end

endmodule

// File: rtl/vu_lane.sv
module vu_lane
    import vu_pkg::*;
#(
    parameter int EW = 8
) (
    input  vu_pkg::uop_e   op,
    input  logic [EW-1:0]  x,
    output logic [EW-1:0]  y
);

    localparam int CW  = $clog2(EW + 1);
    localparam int K8  = (EW > 8)  ? 8  : EW;
    localparam int K16 = (EW > 16) ? 16 : EW;
    localparam int K32 = (EW > 32) ? 32 : EW;

    logic [EW-2:0] below;
    logic [CW-1:0] lz_cnt;
    logic [CW-1:0] ls_cnt;
    logic [CW-1:0] pop_cnt;
    logic          lz_hit;
    logic          ls_hit;

    assign below = x[EW-2:0] ^ {(EW-1){x[EW-1]}};

    function automatic logic [EW-1:0] extend(input logic [EW-1:0] v, input int k,
                                             input logic sgn);
        logic [EW-1:0] r;
        for (int b = 0; b < EW; b++) begin
            r[b] = (b < k) ? v[b] : (sgn & v[k-1]);
        end
        return r;
    endfunction

    always_comb begin
        lz_cnt  = CW'(EW);
        lz_hit  = 1'b0;
        ls_cnt  = CW'(EW - 1);
        ls_hit  = 1'b0;
        pop_cnt = '0;
        for (int b = EW - 1; b >= 0; b--) begin
            if (!lz_hit && x[b]) begin
                lz_cnt = CW'(EW - 1 - b);
                lz_hit = 1'b1;
            end
            pop_cnt = pop_cnt + CW'(x[b]);
        end
        for (int b = EW - 2; b >= 0; b--) begin
            if (!ls_hit && below[b]) begin
                ls_cnt = CW'(EW - 2 - b);
                ls_hit = 1'b1;
            end
        end
    end

    always_comb begin
        case (op)
            UOP_CLS:   y = EW'(ls_cnt);
            UOP_CLZ:   y = EW'(lz_cnt);
            UOP_POPC:  y = EW'(pop_cnt);
            UOP_ZTEST: y = EW'(x == '0);
            UOP_SCLR:  y = {1'b0, x[EW-2:0]};
            UOP_SFLIP: y = {~x[EW-1], x[EW-2:0]};
            UOP_INV:   y = ~x;
            UOP_SXT8:  y = extend(x, K8, 1'b1);
            UOP_ZXT8:  y = extend(x, K8, 1'b0);
            UOP_SXT16: y = extend(x, K16, 1'b1);
            UOP_ZXT16: y = extend(x, K16, 1'b0);
            UOP_SXT32: y = extend(x, K32, 1'b1);
            UOP_ZXT32: y = extend(x, K32, 1'b0);
            UOP_ABS:   y = x[EW-1] ? (EW'(0) - x) : x;
            UOP_NEG:   y = EW'(0) - x;
            default:   y = x;
        endcase
    end

endmodule

// File: rtl/vu_slice.sv
module vu_slice
    import vu_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int EW    = 8
) (
    input  vu_pkg::uop_e      op,
    input  logic [VEC_W-1:0]  src,
    input  logic [VEC_W-1:0]  old,
    input  logic [VEC_W/EW-1:0] act,
    output logic [VEC_W-1:0]  res
);

    localparam int LANES = VEC_W / EW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EW-1:0] lane_y;

        vu_lane #(.EW(EW)) u_lane (
            .op (op),
            .x  (src[i*EW +: EW]),
            .y  (lane_y)
        );

        assign res[i*EW +: EW] = act[i] ? lane_y : old[i*EW +: EW];
    end

endmodule

// File: rtl/vec_unary_unit.sv
module vec_unary_unit
    import vu_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        insn,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   old_vec,
    input  logic [VEC_W/8-1:0] pred,
    output logic [VEC_W-1:0]   out_vec,
    output logic               illegal,
    output logic               done
);

    localparam int PRED_W = VEC_W / 8;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             bad;
        logic             done;
    } state_t;

    dec_t             dec;
    logic [VEC_W-1:0] slice_res [NUM_SIZES];
    state_t           st_d;
    state_t           st_q;

    vu_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int EW    = 8 << k;
        localparam int LANES = VEC_W / EW;
        localparam int STEP  = EW / 8;

        logic [LANES-1:0] act;

        for (genvar i = 0; i < LANES; i++) begin : g_act
            assign act[i] = pred[i*STEP];
        end

        vu_slice #(.VEC_W(VEC_W), .EW(EW)) u_slice (
            .op  (dec.op),
            .src (src_vec),
            .old (old_vec),
            .act (act),
            .res (slice_res[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            st_d.bad = !dec.legal;
            st_d.vec = dec.legal ? slice_res[dec.sz] : old_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vec = st_q.vec;
    assign illegal = st_q.bad;
    assign done    = st_q.done;

    logic unused_pred_w;
    assign unused_pred_w = (PRED_W == 0);

endmodule

// File: rtl/vu_unary_chk.sv
module vu_unary_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      insn,
    input logic [VEC_W-1:0] old_vec,
    input logic [VEC_W-1:0] out_vec,
    input logic             illegal,
    input logic             done
);

    logic unused_chk;
    assign unused_chk = ^insn[15:0];

    // R10: strobe follows the valid input by one edge
    a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R10: no strobe without a valid input
    a_r10_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R10: outputs hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(illegal)));

    // R1: wrong major field is illegal and keeps the destination
    a_r1_bad_major: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[31:24] != 8'h04) |=> (illegal && out_vec == $past(old_vec)));

    // R4: sign-bit operations at byte size are illegal
    a_r4_sign_ops_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[23:22] == 2'b00 && insn[21:19] == 3'b011 &&
         (insn[18:16] == 3'b100 || insn[18:16] == 3'b101)) |=> illegal);

    // R6: word extension below 64 bits is illegal
    a_r6_word_ext_size: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[21:19] == 3'b010 && insn[18:17] == 2'b10 &&
         insn[23:22] != 2'b11) |=> illegal);

    // R9: an illegal result always equals the old destination
    a_r9_illegal_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!illegal || out_vec == $past(old_vec)));

endmodule

bind vec_unary_unit vu_unary_chk #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .insn     (insn),
    .old_vec  (old_vec),
    .out_vec  (out_vec),
    .illegal  (illegal),
    .done     (done)
);

// File: tb/tb_vec_unary_unit.sv
`timescale 1ns/1ps
module tb_vec_unary_unit;

    localparam int VEC_W = 128;
    localparam logic [127:0] SRC_A = 128'h8000_0000_0000_0001_FF80_7F00_0080_FFFE;
    localparam logic [127:0] SRC_B = 128'h00FF_7F80_0140_C0FE_1234_5678_9ABC_DEF0;
    localparam logic [127:0] SRC_Z = 128'h0000_0000_0000_0000_8000_0000_0000_0001;
    localparam logic [127:0] OLD_P = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

    typedef struct packed {
        logic [1:0]   sz;
        logic [2:0]   grp;
        logic [2:0]   opc;
        logic [127:0] src;
        logic [15:0]  prd;
    } tv_t;

    localparam int NTV = 22;
    localparam tv_t TV [NTV] = '{
        '{2'd0, 3'b011, 3'b000, SRC_B, 16'hFFFF},
        '{2'd1, 3'b011, 3'b000, SRC_A, 16'hFFFF},
        '{2'd1, 3'b011, 3'b001, SRC_B, 16'hFFFF},
        '{2'd2, 3'b011, 3'b010, SRC_B, 16'hFFFF},
        '{2'd3, 3'b011, 3'b011, SRC_Z, 16'h0101},
        '{2'd1, 3'b011, 3'b100, SRC_A, 16'h5555},
        '{2'd3, 3'b011, 3'b101, SRC_B, 16'h0100},
        '{2'd0, 3'b011, 3'b110, SRC_B, 16'hA5A5},
        '{2'd1, 3'b010, 3'b000, SRC_A, 16'hFFFF},
        '{2'd2, 3'b010, 3'b001, SRC_A, 16'hFFFF},
        '{2'd2, 3'b010, 3'b010, SRC_A, 16'hFFFF},
        '{2'd3, 3'b010, 3'b011, SRC_B, 16'hFFFF},
        '{2'd3, 3'b010, 3'b100, SRC_A, 16'hFFFF},
        '{2'd3, 3'b010, 3'b101, SRC_A, 16'hFFFF},
        '{2'd0, 3'b010, 3'b110, SRC_A, 16'hFFFF},
        '{2'd2, 3'b010, 3'b111, SRC_B, 16'h0F0F},
        '{2'd1, 3'b010, 3'b111, SRC_B, 16'hAAAA},
        '{2'd0, 3'b011, 3'b100, SRC_A, 16'hFFFF},
        '{2'd1, 3'b010, 3'b010, SRC_A, 16'hFFFF},
        '{2'd2, 3'b010, 3'b100, SRC_A, 16'hFFFF},
        '{2'd2, 3'b011, 3'b111, SRC_A, 16'hFFFF},
        '{2'd2, 3'b000, 3'b000, SRC_A, 16'hFFFF}
    };

    logic               clk;
    logic               rst_n;
    logic               in_valid;
    logic [31:0]        insn;
    logic [VEC_W-1:0]   src_vec;
    logic [VEC_W-1:0]   old_vec;
    logic [VEC_W/8-1:0] pred;
    logic [VEC_W-1:0]   out_vec;
    logic               illegal;
    logic               done;

    int  n_chk;
    int  n_err;
    bit  finished;

    vec_unary_unit #(.VEC_W(VEC_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .insn     (insn),
        .src_vec  (src_vec),
        .old_vec  (old_vec),
        .pred     (pred),
        .out_vec  (out_vec),
        .illegal  (illegal),
        .done     (done)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] g,
                                       input logic [2:0] o);
        return {8'h04, sz, g, o, 3'b101, 3'd2, 5'd9, 5'd4};
    endfunction

    function automatic string req_of(input logic [2:0] g, input logic [2:0] o);
        if (g == 3'b011) begin
            case (o)
                3'b000: return "R2";
                3'b001, 3'b010, 3'b011: return "R3";
                3'b100, 3'b101: return "R4";
                default: return "R5";
            endcase
        end else if (g == 3'b010) begin
            return (o >= 3'b110) ? "R7" : "R6";
        end
        return "R1";
    endfunction

    function automatic logic [63:0] ref_elem(input int g, input int o, input int w,
                                             input logic [63:0] x);
        logic [63:0] m;
        logic [63:0] r;
        logic [63:0] km;
        int          n;
        int          k;
        m = (w == 64) ? '1 : ((64'd1 << w) - 1);
        r = x;
        if (g == 3) begin
            case (o)
                0: begin
                    n = 0;
                    for (int b = w - 2; b >= 0; b--) begin
                        if (x[b] != x[w-1]) break;
                        n++;
                    end
                    r = 64'(n);
                end
                1: begin
                    n = 0;
                    for (int b = w - 1; b >= 0; b--) begin
                        if (x[b]) break;
                        n++;
                    end
                    r = 64'(n);
                end
                2: r = 64'($countones(x));
                3: r = (x == 0) ? 64'd1 : 64'd0;
                4: r = x & ~(64'd1 << (w - 1));
                5: r = x ^ (64'd1 << (w - 1));
                default: r = ~x;
            endcase
        end else begin
            if (o < 6) begin
                k  = (o < 2) ? 8 : ((o < 4) ? 16 : 32);
                km = (64'd1 << k) - 1;
                r  = x & km;
                if ((o % 2 == 0) && x[k-1]) r = r | ~km;
            end else if (o == 6) begin
                r = x[w-1] ? (64'd0 - x) : x;
            end else begin
                r = 64'd0 - x;
            end
        end
        return r & m;
    endfunction

    function automatic logic [128:0] ref_run(input logic [31:0] in, input logic [127:0] s,
                                             input logic [127:0] o, input logic [15:0] p);
        int           w;
        int           g;
        int           op;
        bit           ok;
        logic [127:0] res;
        logic [63:0]  m;
        logic [63:0]  x;
        w  = 8 << in[23:22];
        g  = int'(in[21:19]);
        op = int'(in[18:16]);
        ok = (in[31:24] == 8'h04) && (in[15:13] == 3'b101);
        if (g == 3)      ok = ok && (op != 7) && !((op == 4 || op == 5) && w == 8);
        else if (g == 2) ok = ok && ((op >= 6) || (op < 2 && w > 8) ||
                                     (op < 4 && op >= 2 && w >= 32) || (op >= 4 && w == 64));
        else             ok = 1'b0;
        if (!ok) return {1'b1, o};
        res = o;
        m   = (w == 64) ? '1 : ((64'd1 << w) - 1);
        for (int e = 0; e < 128 / w; e++) begin
            if (p[e*w/8]) begin
                x   = 64'(s >> (e * w)) & m;
                res = (res & ~(128'(m) << (e * w))) |
                      (128'(ref_elem(g, op, w, x)) << (e * w));
            end
        end
        return {1'b0, res};
    endfunction

    task automatic chk(input string rq, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] in, input logic [127:0] s,
                         input logic [127:0] o, input logic [15:0] p);
        @(negedge clk);
        insn     = in;
        src_vec  = s;
        old_vec  = o;
        pred     = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_case(input string rq, input logic [31:0] in, input logic [127:0] s,
                            input logic [15:0] p, input logic [127:0] exp, input logic exp_bad);
        issue(in, s, OLD_P, p);
        chk(rq, "vector", out_vec, exp);
        chk(rq, "illegal", 128'(illegal), 128'(exp_bad));
    endtask

    initial begin
        logic [128:0] want;
        n_chk    = 0;
        n_err    = 0;
        finished = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        insn     = '0;
        src_vec  = '0;
        old_vec  = '0;
        pred     = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "out_vec", out_vec, '0);
        chk("R11", "flags", {126'd0, illegal, done}, '0);
        rst_n = 1'b1;

        for (int t = 0; t < NTV; t++) begin
            logic [31:0] in;
            in   = mk(TV[t].sz, TV[t].grp, TV[t].opc);
            want = ref_run(in, TV[t].src, OLD_P, TV[t].prd);
            issue(in, TV[t].src, OLD_P, TV[t].prd);
            chk(req_of(TV[t].grp, TV[t].opc), "vector", out_vec, want[127:0]);
            chk(want[128] ? "R9" : req_of(TV[t].grp, TV[t].opc), "illegal",
                128'(illegal), 128'(want[128]));
            chk("R10", "done strobe", 128'(done), 128'd1);
        end

        // R2: all-zero and all-one bytes count width-1
        run_case("R2", mk(2'd0, 3'b011, 3'b000), {8{16'h00FF}}, 16'hFFFF, {16{8'h07}}, 1'b0);
        // R3: zero doubleword has leading-zero count of 64
        run_case("R3", mk(2'd3, 3'b011, 3'b001), '0, 16'hFFFF, {2{64'd64}}, 1'b0);
        // R7: most negative byte maps to itself for negate and absolute value
        run_case("R7", mk(2'd0, 3'b010, 3'b111), {16{8'h80}}, 16'hFFFF, {16{8'h80}}, 1'b0);
        run_case("R7", mk(2'd0, 3'b010, 3'b110), {16{8'h80}}, 16'hFFFF, {16{8'h80}}, 1'b0);
        // R8: predicate bits off the lowest byte of each halfword are ignored
        run_case("R8", mk(2'd1, 3'b011, 3'b110), SRC_A, 16'hAAAA, OLD_P, 1'b0);
        // R8: only the lowest byte bit enables a word
        run_case("R8", mk(2'd2, 3'b011, 3'b110), SRC_A, 16'h0001,
                 {OLD_P[127:32], ~SRC_A[31:0]}, 1'b0);
        // R1: wrong tag field
        run_case("R1", {8'h04, 2'd1, 3'b011, 3'b110, 3'b100, 13'h0}, SRC_A, 16'hFFFF, OLD_P, 1'b1);
        // R1: wrong major field
        run_case("R1", {8'h05, 2'd1, 3'b011, 3'b110, 3'b101, 13'h0}, SRC_A, 16'hFFFF, OLD_P, 1'b1);
        // R1: bits 12:0 do not change the outcome
        run_case("R1", {8'h04, 2'd0, 3'b011, 3'b110, 3'b101, 13'h1FFF}, SRC_B, 16'hFFFF, ~SRC_B, 1'b0);
        // R9: legal encoding clears the flag set by the previous illegal one
        run_case("R9", mk(2'd0, 3'b011, 3'b100), SRC_A, 16'hFFFF, OLD_P, 1'b1);
        run_case("R9", mk(2'd3, 3'b011, 3'b100), SRC_A, 16'hFFFF,
                 {1'b0, SRC_A[126:64], 1'b0, SRC_A[62:0]}, 1'b0);

        // R10: strobe drops and result holds while idle
        @(negedge clk);
        chk("R10", "done low when idle", 128'(done), 128'd0);
        src_vec = ~src_vec;
        old_vec = ~old_vec;
        repeat (2) @(negedge clk);
        chk("R10", "result held", out_vec, {1'b0, SRC_A[126:64], 1'b0, SRC_A[62:0]});

        // R11: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "out_vec after reset", out_vec, '0);
        rst_n = 1'b1;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule